// File: doc/BRIEF.md
# Framed Serial Display-Row Loader

This block takes framed serial words from a host over three wires: an active-low select, a serial clock and a data line. All three are brought into a faster system clock domain through two-flop synchronizers. While select is low, each rising edge of the serial clock shifts one data bit into a window that keeps only the most recent 105 bits. When select returns high, the window is decoded.

A frame holds 100 display bits, then a 4-bit row number, then a mode flag. With the flag at 0, the display bits go into one row of a 16-row latch. With the flag at 1, the four bits just before the flag go into a contrast register. A contrast frame is accepted with as few as 5 bits.

A combinational read port returns any row of the latch. The contrast value is always visible on an output. A one-cycle strobe marks every accepted update. An asynchronous active-low reset clears the latch and sets the contrast register to all ones, the setting used when no contrast adjustment is wanted.

Top module: `row_loader`

## Requirements
- R1: While `rst_n` is low, and after it is released, every latch row reads all zeros, `contrast` reads 4'b1111 and `upd` is 0.
- R2: A frame with the mode flag at 0 that carries at least 105 bits writes a row. The first display bit shifted in lands on `rd_data[0]` and the 100th on `rd_data[99]`. The next 4 bits are the row number, most significant bit first, where value 0 selects row 0 and value 15 selects row 15. The last bit is the flag.
- R3: When more than 105 bits are clocked in, only the last 105 before select rises take effect.
- R4: A frame with the mode flag at 0 and fewer than 105 bits changes no row and does not pulse `upd`.
- R5: A frame whose last bit is 1 and that carries at least 5 bits loads the 4 bits before the flag into `contrast`, most significant bit first. It leaves every latch row unchanged.
- R6: A frame with fewer than 5 bits leaves `contrast` unchanged and does not pulse `upd`, even when its last bit is 1.
- R7: `upd` is high for exactly one system clock after each accepted row or contrast write, and for no other cause.
- R8: Serial clock edges that occur while select is high are not counted. Each falling edge of select starts a new, empty bit count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Frame select, active low |
| scl | input | 1 | Serial clock; data is taken on its rising edge |
| sdi | input | 1 | Serial data |
| rd_row | input | 4 | Row number for the read port |
| rd_data | output | 100 | Contents of the selected row |
| contrast | output | 4 | Contrast register |
| upd | output | 1 | One-cycle pulse for each accepted update |

## Verification
A wrong bit count or a misplaced shift window appears at the ports right after select rises. A short frame gets accepted, or a good frame is dropped, and this shows on `upd` within three system clocks of the release. The same fault also shows as rows or a contrast value that differ from the arithmetic model. A wrong mapping of window bits to row number or segment position shows up as soon as the read port addresses the affected row. For this reason the bench writes all 16 rows with distinct patterns and then reads every one of them back. Stray serial clock edges while select is high would change the next short contrast frame from ignored to accepted, which `contrast` reveals at once.

// File: rtl/row_loader.sv
module row_loader #(
  parameter int SEG_W = 100,
  parameter int ROWS  = 16,
  parameter int CON_W = 4,
  parameter int SEL_W = $clog2(ROWS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             scl,
  input  logic             sdi,
  input  logic [SEL_W-1:0] rd_row,
  output logic [SEG_W-1:0] rd_data,
  output logic [CON_W-1:0] contrast,
  output logic             upd
);
  localparam int FL      = SEG_W + SEL_W + 1;
  localparam int CW      = $clog2(FL + 1);
  localparam int CON_MIN = CON_W + 1;

  logic [2:0]       scl_q, cs_q;
  logic [1:0]       sdi_q;
  logic [FL-1:0]    sh;
  logic [CW-1:0]    cnt;
  logic [SEG_W-1:0] lat [ROWS];
  logic [SEG_W-1:0] row_bits;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_q <= '1;
      cs_q  <= '1;
      sdi_q <= '0;
    end else begin
      scl_q <= {scl_q[1:0], scl};
      cs_q  <= {cs_q[1:0], cs_n};
      sdi_q <= {sdi_q[0], sdi};
    end

  wire scl_rise = scl_q[1] & ~scl_q[2];
  wire cs_rise  = cs_q[1] & ~cs_q[2];
  wire cs_fall  = ~cs_q[1] & cs_q[2];
  wire active   = ~cs_q[1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sh  <= '0;
      cnt <= '0;
    end else if (cs_fall || cs_rise) begin
      cnt <= '0;
    end else if (active && scl_rise) begin
      sh <= {sh[FL-2:0], sdi_q[1]};
      if (cnt != CW'(FL)) cnt <= cnt + 1'b1;
    end

  wire             flag = sh[0];
  wire [SEL_W-1:0] sel  = sh[SEL_W:1];
  wire [CON_W-1:0] cval = sh[CON_W:1];
  wire do_row = cs_rise && !flag && (cnt == CW'(FL));
  wire do_con = cs_rise &&  flag && (cnt >= CW'(CON_MIN));

  always_comb
    for (int i = 0; i < SEG_W; i++) row_bits[i] = sh[FL-1-i];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int r = 0; r < ROWS; r++) lat[r] <= '0;
    end else if (do_row) begin
      lat[sel] <= row_bits;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      contrast <= '1;
      upd      <= 1'b0;
    end else begin
      if (do_con) contrast <= cval;
      upd <= do_row | do_con;
    end

  assign rd_data = lat[rd_row];
endmodule

// File: rtl/row_loader_chk.sv
module row_loader_chk #(
  parameter int SEG_W = 100,
  parameter int SEL_W = 4,
  parameter int CON_W = 4,
  parameter int CW    = 7,
  parameter int FL    = 105
) (
  input logic             clk,
  input logic             rst_n,
  input logic             upd,
  input logic [CON_W-1:0] contrast,
  input logic [SEL_W-1:0] rd_row,
  input logic [SEG_W-1:0] rd_data,
  input logic [CW-1:0]    cnt
);
  // R7
  upd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> !upd);

  // R3
  cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(FL));

  // R5
  con_only_on_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(contrast) |-> upd);

  // R4
  row_only_on_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(rd_data) && $stable(rd_row)) |-> upd);

  // R1
  reset_con_chk: assert property (@(posedge clk)
    $rose(rst_n) |-> (contrast == '1 && !upd));
endmodule

bind row_loader row_loader_chk #(
  .SEG_W(SEG_W), .SEL_W(SEL_W), .CON_W(CON_W), .CW(CW), .FL(FL)
) u_chk (
  .clk(clk), .rst_n(rst_n), .upd(upd), .contrast(contrast),
  .rd_row(rd_row), .rd_data(rd_data), .cnt(cnt)
);

// File: tb/sim_row_loader.sv
module sim_row_loader;
  localparam int CLK_P = 10;
  localparam int ROWS  = 16;

  logic        clk = 0, rst_n = 0, cs_n = 1, scl = 1, sdi = 0;
  logic [3:0]  rd_row = 0;
  logic [99:0] rd_data;
  logic [3:0]  contrast;
  logic        upd;

  always #(CLK_P/2) clk = ~clk;

  row_loader u0 (.clk(clk), .rst_n(rst_n), .cs_n(cs_n), .scl(scl), .sdi(sdi),
                 .rd_row(rd_row), .rd_data(rd_data), .contrast(contrast), .upd(upd));

  int total = 0, bad = 0, ups = 0;
  bit fb [0:299];
  int fn;
  logic [99:0] model [ROWS];

  always @(posedge clk) if (rst_n && upd) ups++;

  task automatic chk(input bit ok, input string tag, input logic [99:0] act, input logic [99:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send();
    cs_n = 1; scl = 1; wclk(4);
    cs_n = 0; wclk(4);
    for (int k = 0; k < fn; k++) begin
      scl = 0; sdi = fb[k]; wclk(4);
      scl = 1; wclk(4);
    end
    wclk(4);
    cs_n = 1; wclk(10);
  endtask

  function automatic bit pat(input int r, input int i, input int s);
    return ((i * (r + 3) + s * 5 + r) % 7) < 3;
  endfunction

  task automatic add_pre(input int pre);
    for (int k = 0; k < pre; k++) begin fb[fn] = (k % 3 == 0); fn++; end
  endtask

  task automatic build_row(input int r, input int s, input int pre, input int drop);
    fn = 0;
    add_pre(pre);
    for (int i = drop; i < 100; i++) begin fb[fn] = pat(r, i, s); fn++; end
    for (int b = 3; b >= 0; b--) begin fb[fn] = r[b]; fn++; end
    fb[fn] = 1'b0; fn++;
  endtask

  task automatic build_con(input int v, input int pre);
    fn = 0;
    add_pre(pre);
    for (int b = 3; b >= 0; b--) begin fb[fn] = v[b]; fn++; end
    fb[fn] = 1'b1; fn++;
  endtask

  task automatic set_model(input int r, input int s);
    for (int i = 0; i < 100; i++) model[r][i] = pat(r, i, s);
  endtask

  task automatic check_rows(input string tag);
    for (int r = 0; r < ROWS; r++) begin
      rd_row = 4'(r); #1;
      chk(rd_data === model[r], tag, rd_data, model[r]);
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    total++; bad++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int u0c;
    for (int r = 0; r < ROWS; r++) model[r] = '0;
    wclk(3);
    check_rows("R1 rows in reset");
    chk(contrast === 4'hF, "R1 contrast in reset", 100'(contrast), 100'hF);
    chk(upd === 1'b0, "R1 upd in reset", 100'(upd), 100'h0);
    rst_n = 1; wclk(5);
    chk(contrast === 4'hF, "R1 contrast after reset", 100'(contrast), 100'hF);
    chk(ups == 0, "R1 no strobe after reset", 100'(ups), 100'h0);

    for (int r = 0; r < ROWS; r++) begin
      u0c = ups;
      build_row(r, 1, 0, 0); send(); set_model(r, 1);
      chk(ups == u0c + 1, "R7 one strobe per row write", 100'(ups), 100'(u0c + 1));
    end
    check_rows("R2 row sweep");

    u0c = ups;
    build_row(5, 2, 23, 0); send(); set_model(5, 2);
    build_row(9, 2, 7, 0);  send(); set_model(9, 2);
    check_rows("R3 over-length frames");
    chk(ups == u0c + 2, "R7 strobes for over-length", 100'(ups), 100'(u0c + 2));

    u0c = ups;
    build_row(3, 3, 0, 1); send();
    check_rows("R4 104-bit row frame ignored");
    chk(ups == u0c, "R4 no strobe on short row frame", 100'(ups), 100'(u0c));
    fn = 5; for (int k = 0; k < 5; k++) fb[k] = 1'b0; send();
    check_rows("R4 5-bit flag0 frame ignored");
    chk(ups == u0c, "R4 no strobe on 5-bit flag0", 100'(ups), 100'(u0c));

    for (int v = 0; v < 16; v++) begin
      u0c = ups;
      build_con(v, 0); send();
      chk(contrast === 4'(v), "R5 contrast sweep", 100'(contrast), 100'(v));
      chk(ups == u0c + 1, "R7 one strobe per contrast write", 100'(ups), 100'(u0c + 1));
    end
    check_rows("R5 rows untouched by contrast writes");
    build_con(6, 100); send();
    chk(contrast === 4'd6, "R5 contrast from 105-bit frame", 100'(contrast), 100'd6);
    check_rows("R5 rows untouched by long contrast frame");

    u0c = ups;
    fn = 4; fb[0] = 1; fb[1] = 0; fb[2] = 1; fb[3] = 1; send();
    chk(contrast === 4'd6, "R6 4-bit frame ignored", 100'(contrast), 100'd6);
    chk(ups == u0c, "R6 no strobe on 4-bit frame", 100'(ups), 100'(u0c));

    sdi = 1;
    for (int k = 0; k < 10; k++) begin scl = 0; wclk(4); scl = 1; wclk(4); end
    fn = 4; fb[0] = 0; fb[1] = 0; fb[2] = 1; fb[3] = 1; send();
    chk(contrast === 4'd6, "R8 edges with select high not counted", 100'(contrast), 100'd6);
    chk(ups == u0c, "R8 no strobe", 100'(ups), 100'(u0c));

    rst_n = 0; wclk(3);
    for (int r = 0; r < ROWS; r++) model[r] = '0;
    check_rows("R1 rows cleared by later reset");
    chk(contrast === 4'hF, "R1 contrast restored", 100'(contrast), 100'hF);
    rst_n = 1; wclk(3);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule